// File: doc/BRIEF.md
# Wrapping Line Burst Read Controller

This block is a bus master that fetches one aligned cache line as a burst of single-word beats on a synchronous external bus. A requester hands it an address that may point at any word inside the line. The controller begins the burst with that word and wraps around the line. It raises a one-clock transfer-start strobe, holds transfer-in-progress, chip select and output enable for the whole burst, and collects the returned words into a line buffer. It then pulses a done flag.

The burst follows a 2-1-1-1 cadence. The first word is taken two clocks after transfer start, and each later word one clock after the one before. A mode input, latched with the request, selects one of two terminations. With external termination the slave paces every beat with an acknowledge, and the address is driven once and then held. With internal termination the controller ignores acknowledge, keeps its own fixed schedule, and steps the word-select address bits each beat. All bus strobes are active high.

Top module: `line_burst_reader`

## Requirements
- R1: After reset, busy, done, bus_ts, bus_tip, bus_cs and bus_oe are low and line_data is all zeros.
- R2: A request (req_valid high) is accepted only while busy is low. A request raised during a burst starts no transfer and does not change the line that the burst returns.
- R3: In the clock after a request is accepted, bus_ts is high for exactly one clock, with bus_tip, bus_cs and bus_oe also high.
- R4: bus_tip, bus_cs and bus_oe stay high, without a gap, until the clock in which the fourth beat is captured. All three go low together in the next clock.
- R5: With start word s = req_addr[3:2], beat k (k = 0..3) carries the word at line offset 4*((s+k) mod 4). For example, s = 2 gives the order 8, C, 0, 4.
- R6: Each beat is stored by its word index within the line, not by arrival order. Bits [32*i+31:32*i] of line_data hold the word at line offset 4*i.
- R7: bus_addr equals req_addr with bits [1:0] cleared in the transfer-start clock. With external termination (req_ext_term = 1 at request) it keeps that value for the whole burst.
- R8: With external termination, a beat is captured only on a data-phase clock where bus_ack is high. The controller waits any number of clocks for it.
- R9: With internal termination (req_ext_term = 0), bus_ack is ignored and beats are captured at the 2nd, 3rd, 4th and 5th rising edges after bus_ts is asserted.
- R10: With internal termination, during the data phase bits [3:2] of bus_addr show the word index of the beat in progress, and the upper bits stay constant.
- R11: busy is high from the transfer-start clock through the final beat. done is high for exactly one clock, the one after the fourth capture, and busy is low in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request to read a line |
| req_addr | input | ADDR_W | Byte address of the first word wanted |
| req_ext_term | input | 1 | 1 = beats terminated by slave acknowledge, 0 = fixed internal schedule |
| busy | output | 1 | Burst in progress; requests are not taken |
| done | output | 1 | One-clock pulse when the line buffer is complete |
| line_data | output | LINE_BYTES*8 | Assembled line, word 0 in the low bits |
| bus_addr | output | ADDR_W | Bus address |
| bus_ts | output | 1 | Transfer-start strobe |
| bus_tip | output | 1 | Transfer in progress |
| bus_cs | output | 1 | Chip select |
| bus_oe | output | 1 | Output enable |
| bus_ack | input | 1 | Slave beat acknowledge |
| bus_rdata | input | WORD_BYTES*8 | Read data from the slave |

## Verification
The bench builds the controller with its defaults: 32-bit addresses and 4-byte words in a 16-byte line. That gives four beats and a 2-bit start index, so every start word and every wrap order can be reached with both termination modes. Random acknowledge gaps of up to several clocks exercise indefinite waiting in external mode. In internal mode the bench toggles acknowledge at random to show that it has no effect on the cadence.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_DATA  = 2'd2
    } lbr_phase_e;
endpackage

// File: rtl/lbr_wrap.sv
module lbr_wrap #(
    parameter int IDX_W = 2
) (
    input  logic [IDX_W-1:0] start_idx,
    input  logic [IDX_W-1:0] beat_idx,
    output logic [IDX_W-1:0] slot_idx
);
    // modular add: the carry out of IDX_W bits is the wrap at the line edge
    always_comb begin
        slot_idx = start_idx + beat_idx;
    end
endmodule

// File: rtl/lbr_seq.sv
module lbr_seq
    import lbr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BEATS  = 4,
    parameter int OFF_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic                      req_ext_term,
    input  logic                      bus_ack,
    output logic                      busy,
    output logic                      done,
    output logic                      cap_en,
    output logic [$clog2(BEATS)-1:0]  start_idx,
    output logic [$clog2(BEATS)-1:0]  beat_idx,
    output logic [ADDR_W-1:0]         bus_addr,
    output logic                      bus_ts,
    output logic                      bus_tip,
    output logic                      bus_cs,
    output logic                      bus_oe
);
    localparam int IDX_W = $clog2(BEATS);
    localparam logic [ADDR_W-1:0] WORD_MASK = ADDR_W'((1 << OFF_W) - 1);
    localparam logic [IDX_W-1:0]  LAST_BEAT = IDX_W'(BEATS - 1);

    typedef struct packed {
        lbr_phase_e        phase;
        logic [IDX_W-1:0]  beat;
        logic [IDX_W-1:0]  start;
        logic              ext;
        logic [ADDR_W-1:0] addr;
        logic              ts;
        logic              tip;
        logic              cs;
        logic              oe;
        logic              done;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       take_beat;

    always_comb begin
        take_beat = (st_q.phase == PH_DATA) && (!st_q.ext || bus_ack);
        st_d      = st_q;
        st_d.ts   = 1'b0;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.phase = PH_START;
                    st_d.beat  = '0;
                    st_d.start = req_addr[OFF_W +: IDX_W];
                    st_d.ext   = req_ext_term;
                    st_d.addr  = req_addr & ~WORD_MASK;
                    st_d.ts    = 1'b1;
                    st_d.tip   = 1'b1;
                    st_d.cs    = 1'b1;
                    st_d.oe    = 1'b1;
                end
            end
            PH_START: begin
                st_d.phase = PH_DATA;
            end
            PH_DATA: begin
                if (take_beat) begin
                    if (st_q.beat == LAST_BEAT) begin
                        st_d.phase = PH_IDLE;
                        st_d.tip   = 1'b0;
                        st_d.cs    = 1'b0;
                        st_d.oe    = 1'b0;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.beat = st_q.beat + IDX_W'(1);
                        if (!st_q.ext) begin
                            st_d.addr[OFF_W +: IDX_W] = st_q.start + st_q.beat + IDX_W'(1);
                        end
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = (st_q.phase != PH_IDLE);
    assign done      = st_q.done;
    assign cap_en    = take_beat;
    assign start_idx = st_q.start;
    assign beat_idx  = st_q.beat;
    assign bus_addr  = st_q.addr;
    assign bus_ts    = st_q.ts;
    assign bus_tip   = st_q.tip;
    assign bus_cs    = st_q.cs;
    assign bus_oe    = st_q.oe;
endmodule

// File: rtl/lbr_linebuf.sv
module lbr_linebuf #(
    parameter int BEATS  = 4,
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(BEATS)-1:0]   wr_slot,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [BEATS*DATA_W-1:0]    line_data
);
    localparam int IDX_W = $clog2(BEATS);

    logic [DATA_W-1:0] slot_d [BEATS];
    logic [DATA_W-1:0] slot_q [BEATS];

    generate
        for (genvar g = 0; g < BEATS; g++) begin : g_slot
            always_comb begin
                slot_d[g] = slot_q[g];
                if (wr_en && (wr_slot == IDX_W'(g))) begin
                    slot_d[g] = wr_data;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    slot_q[g] <= '0;
                end else begin
                    slot_q[g] <= slot_d[g];
                end
            end

            assign line_data[g*DATA_W +: DATA_W] = slot_q[g];
        end
    endgenerate
endmodule

// File: rtl/line_burst_reader.sv
module line_burst_reader #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic                      req_ext_term,
    output logic                      busy,
    output logic                      done,
    output logic [LINE_BYTES*8-1:0]   line_data,
    output logic [ADDR_W-1:0]         bus_addr,
    output logic                      bus_ts,
    output logic                      bus_tip,
    output logic                      bus_cs,
    output logic                      bus_oe,
    input  logic                      bus_ack,
    input  logic [WORD_BYTES*8-1:0]   bus_rdata
);
    localparam int BEATS  = LINE_BYTES / WORD_BYTES;
    localparam int IDX_W  = $clog2(BEATS);
    localparam int OFF_W  = $clog2(WORD_BYTES);
    localparam int DATA_W = WORD_BYTES * 8;

    logic             cap_en;
    logic [IDX_W-1:0] start_idx;
    logic [IDX_W-1:0] beat_idx;
    logic [IDX_W-1:0] slot_idx;

    lbr_seq #(
        .ADDR_W (ADDR_W),
        .BEATS  (BEATS),
        .OFF_W  (OFF_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_ext_term (req_ext_term),
        .bus_ack      (bus_ack),
        .busy         (busy),
        .done         (done),
        .cap_en       (cap_en),
        .start_idx    (start_idx),
        .beat_idx     (beat_idx),
        .bus_addr     (bus_addr),
        .bus_ts       (bus_ts),
        .bus_tip      (bus_tip),
        .bus_cs       (bus_cs),
        .bus_oe       (bus_oe)
    );

    lbr_wrap #(
        .IDX_W (IDX_W)
    ) u_wrap (
        .start_idx (start_idx),
        .beat_idx  (beat_idx),
        .slot_idx  (slot_idx)
    );

    lbr_linebuf #(
        .BEATS  (BEATS),
        .DATA_W (DATA_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cap_en),
        .wr_slot   (slot_idx),
        .wr_data   (bus_rdata),
        .line_data (line_data)
    );
endmodule

// File: rtl/lbr_checker.sv
module lbr_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ext_term,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ts,
    input logic              bus_tip,
    input logic              bus_cs,
    input logic              bus_oe
);
    logic       mode_ext_q;
    logic [3:0] tip_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_ext_q <= 1'b0;
            tip_cnt_q  <= '0;
        end else begin
            if (req_valid && !busy) mode_ext_q <= req_ext_term;
            if (bus_ts) tip_cnt_q <= 4'd1;
            else if (bus_tip && tip_cnt_q != 4'hF) tip_cnt_q <= tip_cnt_q + 4'd1;
        end
    end

    assert_held_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !bus_ts);
    assert_ts_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ts |=> !bus_ts);
    assert_ts_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ts |-> (bus_tip && bus_cs && bus_oe));
    assert_strobes_track_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs == bus_tip) && (bus_oe == bus_tip));
    assert_ext_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ext_q && bus_tip && !bus_ts) |-> $stable(bus_addr));
    assert_int_cadence_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mode_ext_q) |-> (tip_cnt_q == 4'd5));
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !bus_tip));
endmodule

bind line_burst_reader lbr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ext_term (req_ext_term),
    .busy         (busy),
    .done         (done),
    .bus_addr     (bus_addr),
    .bus_ts       (bus_ts),
    .bus_tip      (bus_tip),
    .bus_cs       (bus_cs),
    .bus_oe       (bus_oe)
);

// File: tb/sim_line_burst_reader.sv
`timescale 1ns/1ps
module sim_line_burst_reader;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [31:0]  req_addr = '0;
    logic         req_ext_term = 1'b0;
    logic         busy, done;
    logic [127:0] line_data;
    logic [31:0]  bus_addr;
    logic         bus_ts, bus_tip, bus_cs, bus_oe;
    logic         bus_ack = 1'b0;
    logic [31:0]  bus_rdata = '0;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    line_burst_reader u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ext_term(req_ext_term), .busy(busy), .done(done), .line_data(line_data),
        .bus_addr(bus_addr), .bus_ts(bus_ts), .bus_tip(bus_tip), .bus_cs(bus_cs),
        .bus_oe(bus_oe), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0] ^ 16'hC3A5, a[31:16] ^ 16'h1E0F};
    endfunction

    function automatic logic [127:0] exp_line(input logic [31:0] a);
        logic [127:0] r;
        for (int i = 0; i < 4; i++) r[i*32 +: 32] = mem_word({a[31:4], 4'b0} + 32'(i*4));
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    task automatic burst(input logic [31:0] a, input bit ext, input bit hold_req, input int maxgap);
        logic [1:0]  s = a[3:2];
        logic [31:0] base = {a[31:4], 4'b0};
        int k = 0;
        int ncyc = 0;
        int wcnt = 0;
        int gap = $urandom_range(0, maxgap);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_ext_term = ext; bus_ack = 1'b0;
        @(posedge clk);
        @(negedge clk);
        if (hold_req) begin req_addr = a ^ 32'h0000_0054; req_ext_term = ~ext; end
        else req_valid = 1'b0;
        chk(bus_ts && bus_tip && bus_cs && bus_oe, "R3 start strobes", {bus_ts, bus_tip, bus_cs, bus_oe}, 4'hF);
        chk(busy, "R11 busy at start", busy, 1);
        chk(bus_addr == {a[31:2], 2'b00}, "R7 start address", bus_addr, {a[31:2], 2'b00});
        while (k < 4) begin
            @(posedge clk);
            @(negedge clk);
            ncyc++;
            chk(!bus_ts, "R3 ts single pulse / R2 no restart", bus_ts, 0);
            chk(bus_tip && bus_cs && bus_oe && busy, "R4 strobes held", {bus_tip, bus_cs, bus_oe, busy}, 4'hF);
            if (ext) chk(bus_addr == {a[31:2], 2'b00}, "R7 address held", bus_addr, {a[31:2], 2'b00});
            else chk(bus_addr == {a[31:4], s + 2'(k), 2'b00}, "R10 stepped address", bus_addr, {a[31:4], s + 2'(k), 2'b00});
            if (ext) begin
                bus_ack = (wcnt == gap);
                bus_rdata = bus_ack ? mem_word(base + 32'({s + 2'(k), 2'b00})) : 32'hDEAD_0000 ^ 32'(ncyc);
                if (bus_ack) begin k++; wcnt = 0; gap = $urandom_range(0, maxgap); end
                else wcnt++;
            end else begin
                bus_ack = 1'($urandom);
                bus_rdata = mem_word(base + 32'({s + 2'(k), 2'b00}));
                k++;
            end
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; bus_ack = 1'b0;
        chk(done && !busy, "R11 done pulse, busy low", {done, busy}, 2'b10);
        chk(!bus_tip && !bus_cs && !bus_oe, "R4 strobes released", {bus_tip, bus_cs, bus_oe}, 0);
        chk(line_data == exp_line(a), "R5 R6 R8 line content", line_data, exp_line(a));
        if (!ext) chk(ncyc == 4, "R9 internal cadence 2-1-1-1", ncyc, 4);
        @(negedge clk);
        chk(!done && !bus_ts, "R11 done one clock / R2 no extra burst", {done, bus_ts}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !bus_ts && !bus_tip && !bus_cs && !bus_oe, "R1 reset strobes",
            {busy, done, bus_ts, bus_tip, bus_cs, bus_oe}, 0);
        chk(line_data == '0, "R1 reset buffer", line_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // directed: every start word, both terminations
        for (int s = 0; s < 4; s++) burst(32'h1234_5670 | 32'(s * 4), 1'b0, 1'b0, 0);
        for (int s = 0; s < 4; s++) burst(32'h8000_1a0f ^ 32'(s * 4), 1'b1, 1'b0, 0);
        // long slave stalls (R8)
        burst(32'hFFFF_FFFC, 1'b1, 1'b0, 7);
        // request held high through a burst (R2)
        burst(32'h0F0F_0F08, 1'b0, 1'b1, 0);
        burst(32'h3C3C_3C34, 1'b1, 1'b1, 3);
        // random mix
        for (int i = 0; i < 40; i++) burst($urandom, 1'($urandom), 1'($urandom), 4);
        summary();
    end
endmodule